// File: doc/BRIEF.md
# DMA Channel Controller with Graceful Stop

This block sequences the bus cycles of one DMA channel. A transfer moves one unit. In dual-address mode it takes a read cycle and then a write cycle. In single-address mode it takes one combined cycle. Requests arrive on one line. The line is either edge-detected or level-detected. The channel runs in one of two modes:

- **Cycle-steal:** one transfer is granted per request.
- **Burst:** a single rising edge keeps the channel running.

A down-counter limits the number of transfers. The done flag rises when the counter reaches zero.

Software halts the channel by clearing the channel enable or the global enable. Either one stops the channel, and neither stop is abrupt. A bus cycle that has started always finishes. A read that has started is always followed by its write. The enables are examined only at the idle boundary between transfers, which is the same point where the request is sampled. For this reason, stop latency is the same in every request mode. The remaining count survives a stop, so the channel resumes when it is re-enabled.

Top module: `dma_stop_channel`

## Requirements
- R1: After reset, all strobes, `active_o` and `done_o` are 0, and `count_o` is 0.
- R2: A transfer starts only from idle, and only when `ch_en_i` and `glob_en_i` are both 1 and `count_o` is non-zero. A request seen while any of these is false is discarded.
- R3: At most one of `rd_o`, `wr_o` and `sa_o` is 1 at a time. Each strobe holds until a cycle in which `bus_done_i` is 1.
- R4: With `dual_i`=1, each transfer is one `rd_o` cycle followed by one `wr_o` cycle. With `dual_i`=0, each transfer is one `sa_o` cycle.
- R5: `count_o` drops by one when a `wr_o` or `sa_o` cycle completes. When it reaches 0, `done_o` becomes 1 and no further transfer starts.
- R6: In cycle-steal mode (`burst_i`=0, `level_i`=0), each rising edge of `req_i` grants exactly one transfer.
- R7: With `level_i`=1, in either mode, `req_i` is sampled at each idle boundary. While it is low, the channel pauses and the enables keep their values.
- R8: In burst edge mode (`burst_i`=1, `level_i`=0), one rising edge runs transfers back to back until the count reaches 0 or an enable is cleared. After a stop, a new edge is needed.
- R9: Clearing either enable while a read is in progress still lets that read and its write complete. The channel then goes idle.
- R10: After a stop, `count_o` keeps its remaining value. Re-enabling continues the count from that value.
- R11: `cnt_load_i` loads `cnt_val_i` and clears `done_o` only while the channel is idle. While `active_o` is 1, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Transfer request |
| burst_i | input | 1 | 1 = burst mode, 0 = cycle-steal |
| level_i | input | 1 | 1 = level-detected request, 0 = edge |
| dual_i | input | 1 | 1 = read/write pair, 0 = single cycle |
| ch_en_i | input | 1 | Channel enable |
| glob_en_i | input | 1 | Global enable |
| cnt_load_i | input | 1 | Load transfer count |
| cnt_val_i | input | CNT_W | Count to load |
| bus_done_i | input | 1 | Current bus cycle completes this clock |
| rd_o | output | 1 | Read cycle strobe |
| wr_o | output | 1 | Write cycle strobe |
| sa_o | output | 1 | Single-address cycle strobe |
| active_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | Count reached zero |
| count_o | output | CNT_W | Remaining transfers |

## Verification
A wrong phase state becomes visible within one bus cycle. It shows up as a strobe outside its order: a write with no read before it, a read with no write after it, or a strobe while the channel is disabled. The scoreboard of expected strobes reports the first such cycle.

A wrong request or enable flag shows up differently, as a missing or extra transfer. Here the queue is left non-empty, or a strobe appears with no expected entry.

Counter faults show up in `count_o` and `done_o` at the end of each phase. They are most visible after a stop in the middle of a read and after a resume.

// File: rtl/dma_stop_channel.sv
module dma_stop_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             burst_i,
  input  logic             level_i,
  input  logic             dual_i,
  input  logic             ch_en_i,
  input  logic             glob_en_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             bus_done_i,
  output logic             rd_o,
  output logic             wr_o,
  output logic             sa_o,
  output logic             active_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_SA} st_t;

  st_t              st;
  logic             req_q, edge_pend, burst_run, done_q;
  logic [CNT_W-1:0] cnt;

  wire run_ok   = ch_en_i & glob_en_i & (cnt != '0);
  wire req_rise = req_i & ~req_q;
  wire want     = level_i ? req_i : (burst_i ? burst_run : edge_pend);
  wire idle     = (st == S_IDLE);
  wire start    = idle & run_ok & want;
  wire unit_end = ((st == S_WR) | (st == S_SA)) & bus_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start) st <= dual_i ? S_RD : S_SA;
        S_RD:   if (bus_done_i) st <= S_WR;
        S_WR:   if (bus_done_i) st <= S_IDLE;
        S_SA:   if (bus_done_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      edge_pend <= 1'b0;
      burst_run <= 1'b0;
    end else begin
      req_q <= req_i;
      if (!run_ok)    edge_pend <= 1'b0;
      else if (start) edge_pend <= req_rise;
      else if (req_rise) edge_pend <= 1'b1;
      if (!run_ok) burst_run <= 1'b0;
      else if (req_rise & burst_i & ~level_i) burst_run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (cnt_load_i && idle) begin
      cnt    <= cnt_val_i;
      done_q <= 1'b0;
    end else if (unit_end) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) done_q <= 1'b1;
    end
  end

  assign rd_o     = (st == S_RD);
  assign wr_o     = (st == S_WR);
  assign sa_o     = (st == S_SA);
  assign active_o = ~idle;
  assign done_o   = done_q;
  assign count_o  = cnt;

endmodule

module dma_stop_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dual_i,
  input logic             ch_en_i,
  input logic             glob_en_i,
  input logic             cnt_load_i,
  input logic             bus_done_i,
  input logic             rd_o,
  input logic             wr_o,
  input logic             sa_o,
  input logic             active_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o
);

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_o, wr_o, sa_o}));

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_o | wr_o | sa_o) && !bus_done_i) |=> $stable({rd_o, wr_o, sa_o}));

  // R9
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && bus_done_i) |=> wr_o);

  // R2
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !(ch_en_i && glob_en_i)) |=> !active_o);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_o || sa_o) && bus_done_i) |=> (count_o == $past(count_o) - 1'b1));

  // R5
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (count_o == '0));

  // R11
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o && cnt_load_i) |=> $stable(count_o));

  // R4
  single_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !dual_i) |=> !rd_o);

endmodule

bind dma_stop_channel dma_stop_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual_i(dual_i), .ch_en_i(ch_en_i),
  .glob_en_i(glob_en_i), .cnt_load_i(cnt_load_i), .bus_done_i(bus_done_i),
  .rd_o(rd_o), .wr_o(wr_o), .sa_o(sa_o), .active_o(active_o),
  .done_o(done_o), .count_o(count_o)
);

// File: tb/dma_stop_channel_bench.sv
`timescale 1ns/1ps
module dma_stop_channel_bench;
  localparam int CNT_W = 16;

  logic clk = 0, rst_n = 0;
  logic req = 0, burst = 0, level = 0, dual = 0, ch_en = 0, glob_en = 0;
  logic cnt_load = 0, ack_en = 1;
  logic [CNT_W-1:0] cnt_val = '0;
  logic bus_done, rd, wr, sa, active, done;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0;
  byte exp_q[$];

  always #10 clk = ~clk;

  assign bus_done = ack_en & (rd | wr | sa);

  dma_stop_channel #(.CNT_W(CNT_W)) u_dma_stop_channel (
    .clk(clk), .rst_n(rst_n), .req_i(req), .burst_i(burst), .level_i(level),
    .dual_i(dual), .ch_en_i(ch_en), .glob_en_i(glob_en), .cnt_load_i(cnt_load),
    .cnt_val_i(cnt_val), .bus_done_i(bus_done), .rd_o(rd), .wr_o(wr), .sa_o(sa),
    .active_o(active), .done_o(done), .count_o(count));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(byte op, int n);
    repeat (n) exp_q.push_back(op);
  endtask

  task automatic pulse_req();
    req = 1; cyc(1); req = 0;
  endtask

  task automatic load(int v);
    ch_en = 0; glob_en = 0; cnt_val = CNT_W'(v);
    cnt_load = 1; cyc(1); cnt_load = 0;
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 50 && !(rd | sa); i++) cyc(1);
  endtask

  // monitor: pops one expected op per completed bus cycle
  always @(negedge clk) begin
    if (rst_n && bus_done) begin
      byte got;
      got = rd ? "R" : (wr ? "W" : "S");
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R4: actual op %c expected none", got);
      end else begin
        byte e;
        e = exp_q.pop_front();
        if (e != got) begin
          errors++;
          $display("FAIL R4/R9: actual op %c expected %c", got, e);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    // R1
    check("R1 active", active, 0); check("R1 strobes", {rd, wr, sa}, 0);
    check("R1 done", done, 0); check("R1 count", count, 0);
    rst_n = 1; cyc(2);

    // R6 R4: cycle-steal edge, dual, two edges -> two pairs
    load(4); ch_en = 1; glob_en = 1; dual = 1;
    push("R", 1); push("W", 1); pulse_req(); cyc(8);
    push("R", 1); push("W", 1); pulse_req(); cyc(8);
    check("R6 count", count, 2); check("R6 queue", exp_q.size(), 0);

    // R7 R5: level, single, held high until count expires
    load(2); ch_en = 1; glob_en = 1; dual = 0; level = 1;
    push("S", 2); req = 1; cyc(12); req = 0;
    check("R5 count", count, 0); check("R5 done", done, 1);
    check("R5 queue", exp_q.size(), 0);

    // R2: zero count, then disabled channel -> no transfer
    level = 0; pulse_req(); cyc(5);
    check("R2 zero count idle", active, 0);
    load(3); ch_en = 0; glob_en = 1; pulse_req(); cyc(5);
    check("R2 disabled idle", active, 0);
    ch_en = 1; cyc(5);
    check("R2 stale edge dropped", count, 3);

    // R8: burst edge, single, one edge runs all
    load(5); ch_en = 1; glob_en = 1; burst = 1; level = 0;
    push("S", 5); pulse_req(); cyc(20);
    check("R8 count", count, 0); check("R8 done", done, 1);
    check("R8 queue", exp_q.size(), 0);

    // R9 R10: global stop during read, pair completes, then resume
    load(6); ch_en = 1; glob_en = 1; dual = 1; ack_en = 0;
    push("R", 1); push("W", 1); pulse_req(); wait_strobe();
    glob_en = 0; cyc(2); ack_en = 1; cyc(10);
    check("R9 stopped", active, 0); check("R10 count kept", count, 5);
    check("R9 queue", exp_q.size(), 0);
    glob_en = 1; cyc(5);
    check("R8 needs new edge", count, 5);
    push("R", 1); push("W", 1); push("R", 1); push("W", 1);
    push("R", 1); push("W", 1); push("R", 1); push("W", 1);
    push("R", 1); push("W", 1);
    pulse_req(); cyc(40);
    check("R10 resume count", count, 0); check("R10 done", done, 1);
    check("R10 queue", exp_q.size(), 0);

    // R9: channel-enable stop in burst, single
    load(4); ch_en = 1; glob_en = 1; dual = 0; ack_en = 0;
    push("S", 1); pulse_req(); wait_strobe();
    ch_en = 0; cyc(2); ack_en = 1; cyc(10);
    check("R9 ch stop count", count, 3); check("R9 ch stop queue", exp_q.size(), 0);

    // R7: burst level pauses when request drops
    load(3); ch_en = 1; glob_en = 1; burst = 1; level = 1; ack_en = 0;
    push("S", 1); req = 1; wait_strobe(); req = 0; ack_en = 1; cyc(8);
    check("R7 paused count", count, 2); check("R7 paused idle", active, 0);
    check("R7 enable kept", ch_en, 1);
    push("S", 2); req = 1; cyc(10); req = 0;
    check("R7 resumed count", count, 0); check("R7 queue", exp_q.size(), 0);

    // R11: load ignored while active
    load(3); ch_en = 1; glob_en = 1; burst = 0; level = 0; ack_en = 0;
    push("S", 1); pulse_req(); wait_strobe();
    cnt_val = 9; cnt_load = 1; cyc(1); cnt_load = 0;
    ack_en = 1; cyc(6);
    check("R11 load ignored", count, 2); check("R11 done clear", done, 0);
    check("R11 queue", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule